// File: doc/BRIEF.md
# Dual 32-bit Interval Timer

This peripheral holds two independent 32-bit up-counters, a low half and a high half. Software reaches them through a small word-addressed register bank. Each half has its own count register, its own period register and a 2-bit enable mode. The two mode fields share a single control word. A global control word selects the operating mode and releases each half from reset.

A running half counts one step per clock. In looping mode it wraps to zero after it reaches its period. In single-shot mode it stops at the period and clears its own mode field. In both modes it emits a one-cycle event pulse. With a period of all ones, a looping half is a free-running time base that software can read at any moment. An optional compare register on the low half schedules an extra event without disturbing the count. Each event also sets a sticky status flag. Software clears a flag by writing one to its bit. The interrupt line is high while any flag is set.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads zero, and the event outputs and the interrupt output are low.
- R2: A half whose release bit is 0 holds its count at zero and ignores count writes. Global control bit 0 releases the low half and bit 1 releases the high half.
- R3: A half advances only while released, while global control bits [3:2] hold 01, and while its mode field holds 01 (single-shot) or 10 (looping). The low field sits at control bits [7:6] and the high field at bits [23:22]. Mode 00 or any other timer mode freezes the count.
- R4: In looping mode the count goes 0,1,…,P,0 for period P. An event pulse one cycle wide appears in the cycle after the count held P.
- R5: In single-shot mode the count stops at P, one event pulse is emitted, and the half's mode field reads back 00 afterwards.
- R6: A value written to a count register (low 0x10, high 0x14) is the count right after that clock edge.
- R7: Rewriting the control word with the other half's existing mode value leaves that half counting without a break.
- R8: When the low count equals the compare register (0x30) while the low half is running, one compare event is emitted and the count keeps advancing.
- R9: Status at 0x44 holds sticky flags: bit 0 for the low event, bit 1 for the high event, bit 2 for the compare event. Writing 1 to a bit clears that flag. The interrupt output is high while any flag is set.
- R10: Reads of unmapped offsets return zero, and writes to them change nothing.
- R11: Read data appears on the read-data port one cycle after the read strobe. It reflects register contents at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lo_evt | output | 1 | Low half period event pulse |
| hi_evt | output | 1 | High half period event pulse |
| cmp_evt | output | 1 | Low half compare event pulse |
| irq | output | 1 | Any sticky flag set |

## Verification
The assertions assume that the bus never raises the read and write strobes together. They also assume that the address presented with a strobe is stable for that single cycle. The stimulus drives every access through one task that asserts exactly one strobe for one cycle at the falling edge. Random periods are loaded only while the high half is disabled and its count is cleared. This keeps the count below the new period, so the wrap arithmetic the bench expects always applies.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_ONCE = 2'b01;
  localparam logic [1:0] MODE_LOOP = 2'b10;
  localparam logic [1:0] TMODE_DUAL = 2'b01;

  localparam int OFF_CNT0 = 'h10;
  localparam int OFF_PRD0 = 'h18;
  localparam int OFF_CTRL = 'h20;
  localparam int OFF_GCTL = 'h24;
  localparam int OFF_CMP  = 'h30;
  localparam int OFF_STAT = 'h44;

  localparam int MODE_LSB_LO = 6;
  localparam int MODE_LSB_HI = 22;

  function automatic int mode_lsb(input int idx);
    return (idx == 0) ? MODE_LSB_LO : MODE_LSB_HI;
  endfunction
endpackage

// File: rtl/dtmr_half.sv
module dtmr_half import dtmr_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rel_i,
  input  logic         run_ok_i,
  input  logic         cnt_we_i,
  input  logic         prd_we_i,
  input  logic         mode_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [1:0]   mode_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] prd_o,
  output logic [1:0]   mode_o,
  output logic         run_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, prd_q;
  logic [1:0]   mode_q;
  logic         run, hit;

  assign run = rel_i && run_ok_i && (mode_q == MODE_ONCE || mode_q == MODE_LOOP);
  assign hit = run && (cnt_q == prd_q) && !cnt_we_i;

  always_ff @(posedge clk) begin
    if (rst || !rel_i) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (run) begin
      if (hit) begin
        if (mode_q == MODE_LOOP) cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      if (prd_we_i) prd_q <= wdata_i;
      if (mode_we_i) mode_q <= mode_wdata_i;
      else if (hit && mode_q == MODE_ONCE) mode_q <= MODE_OFF;
    end
  end

  assign cnt_o  = cnt_q;
  assign prd_o  = prd_q;
  assign mode_o = mode_q;
  assign run_o  = run;
  assign hit_o  = hit;
endmodule

// File: rtl/dtmr_evt.sv
module dtmr_evt #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] evt_o,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] evt_q, flag_q, flag_d;
  logic         irq_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_we_i) flag_d = flag_d & ~clr_mask_i;
    flag_d = flag_d | hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      evt_q  <= hit_i;
      flag_q <= flag_d;
      irq_q  <= |flag_d;
    end
  end

  assign evt_o  = evt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dual_timer.sv
module dual_timer import dtmr_pkg::*; #(
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          lo_evt,
  output logic          hi_evt,
  output logic          cmp_evt,
  output logic          irq
);
  localparam int NH  = 2;
  localparam int NEV = NH + 1;

  logic [1:0]    gctl_rel, gctl_mode;
  logic          run_ok;
  logic [DW-1:0] cnt_a [NH];
  logic [DW-1:0] prd_a [NH];
  logic [1:0]    mode_a[NH];
  logic [NH-1:0] hit, run, cnt_we, prd_we;
  logic          ctrl_we, gctl_we, cmp_we, stat_we;
  logic [DW-1:0] cmp_val;
  logic          cmp_hit;
  logic [NEV-1:0] evt, flag;
  logic [DW-1:0] rd_mux, ctrl_rd;

  assign ctrl_we = bus_wr && (bus_addr == AW'(OFF_CTRL));
  assign gctl_we = bus_wr && (bus_addr == AW'(OFF_GCTL));
  assign cmp_we  = bus_wr && (bus_addr == AW'(OFF_CMP));
  assign stat_we = bus_wr && (bus_addr == AW'(OFF_STAT));
  assign run_ok  = (gctl_mode == TMODE_DUAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_rel  <= '0;
      gctl_mode <= '0;
    end else if (gctl_we) begin
      gctl_rel  <= bus_wdata[1:0];
      gctl_mode <= bus_wdata[3:2];
    end
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    localparam int ML = mode_lsb(i);
    assign cnt_we[i] = bus_wr && (bus_addr == AW'(OFF_CNT0 + 4*i));
    assign prd_we[i] = bus_wr && (bus_addr == AW'(OFF_PRD0 + 4*i));
    dtmr_half #(.W(DW)) u_half (
      .clk          (clk),
      .rst          (rst),
      .rel_i        (gctl_rel[i]),
      .run_ok_i     (run_ok),
      .cnt_we_i     (cnt_we[i]),
      .prd_we_i     (prd_we[i]),
      .mode_we_i    (ctrl_we),
      .wdata_i      (bus_wdata),
      .mode_wdata_i (bus_wdata[ML +: 2]),
      .cnt_o        (cnt_a[i]),
      .prd_o        (prd_a[i]),
      .mode_o       (mode_a[i]),
      .run_o        (run[i]),
      .hit_o        (hit[i])
    );
  end

  if (HAS_CMP) begin : g_cmp
    logic [DW-1:0] cmp_q;
    always_ff @(posedge clk) begin
      if (rst) cmp_q <= '0;
      else if (cmp_we) cmp_q <= bus_wdata;
    end
    assign cmp_val = cmp_q;
    assign cmp_hit = run[0] && (cnt_a[0] == cmp_q);
  end else begin : g_nocmp
    assign cmp_val = '0;
    assign cmp_hit = 1'b0;
  end

  dtmr_evt #(.N(NEV)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .hit_i      ({cmp_hit, hit}),
    .clr_we_i   (stat_we),
    .clr_mask_i (bus_wdata[NEV-1:0]),
    .evt_o      (evt),
    .flag_o     (flag),
    .irq_o      (irq)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[MODE_LSB_LO +: 2] = mode_a[0];
    ctrl_rd[MODE_LSB_HI +: 2] = mode_a[1];
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFF_CNT0))          rd_mux = cnt_a[0];
    else if (bus_addr == AW'(OFF_CNT0 + 4)) rd_mux = cnt_a[1];
    else if (bus_addr == AW'(OFF_PRD0))     rd_mux = prd_a[0];
    else if (bus_addr == AW'(OFF_PRD0 + 4)) rd_mux = prd_a[1];
    else if (bus_addr == AW'(OFF_CTRL))     rd_mux = ctrl_rd;
    else if (bus_addr == AW'(OFF_GCTL))     rd_mux = DW'({gctl_mode, gctl_rel});
    else if (bus_addr == AW'(OFF_CMP))      rd_mux = cmp_val;
    else if (bus_addr == AW'(OFF_STAT))     rd_mux = DW'(flag);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign lo_evt  = evt[0];
  assign hi_evt  = evt[1];
  assign cmp_evt = evt[2];
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    rel,
  input logic          run_ok,
  input logic [DW-1:0] cnt_lo,
  input logic [1:0]    mode_lo,
  input logic          hit_lo,
  input logic          cnt_we_lo,
  input logic          ctrl_we,
  input logic [DW-1:0] wdata,
  input logic          lo_evt,
  input logic          cmp_evt,
  input logic [2:0]    flag
);
  // R2: unreleased low half reads zero next cycle
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rel[0] |=> cnt_lo == '0);

  // R3: a running half not at its period advances by one
  p_count_r3: assert property (@(posedge clk) disable iff (rst)
    (rel[0] && run_ok && (mode_lo == 2'b01 || mode_lo == 2'b10) && !hit_lo && !cnt_we_lo)
      |=> cnt_lo == $past(cnt_lo) + 1'b1);

  // R4: looping half returns to zero after its period
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && mode_lo == 2'b10) |=> cnt_lo == '0);

  // R5: single-shot half disables itself and holds its count
  p_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && mode_lo == 2'b01 && !ctrl_we) |=> (mode_lo == 2'b00 && $stable(cnt_lo)));

  // R6: a count write takes effect on the next edge
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_we_lo && rel[0]) |=> cnt_lo == $past(wdata));

  // R9: a pulse is always accompanied by its sticky flag
  p_flag_r9: assert property (@(posedge clk) disable iff (rst)
    lo_evt |-> flag[0]);
  p_cflag_r9: assert property (@(posedge clk) disable iff (rst)
    cmp_evt |-> flag[2]);
endmodule

bind dual_timer dtmr_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rel       (gctl_rel),
  .run_ok    (run_ok),
  .cnt_lo    (cnt_a[0]),
  .mode_lo   (mode_a[0]),
  .hit_lo    (hit[0]),
  .cnt_we_lo (cnt_we[0]),
  .ctrl_we   (ctrl_we),
  .wdata     (bus_wdata),
  .lo_evt    (lo_evt),
  .cmp_evt   (cmp_evt),
  .flag      (flag)
);

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lo_evt, hi_evt, cmp_evt, irq;

  int checks = 0, failures = 0;
  int cyc = 0, cap = 0;
  int n_lo = 0, n_hi = 0, n_cmp = 0;
  bit done = 0;

  localparam logic [7:0] A_CL = 8'h10, A_CH = 8'h14, A_PL = 8'h18, A_PH = 8'h1C;
  localparam logic [7:0] A_CTRL = 8'h20, A_GCTL = 8'h24, A_CMP = 8'h30, A_STAT = 8'h44;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (lo_evt)  n_lo  <= n_lo + 1;
    if (hi_evt)  n_hi  <= n_hi + 1;
    if (cmp_evt) n_cmp <= n_cmp + 1;
  end

  dual_timer u_dual_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lo_evt(lo_evt), .hi_evt(hi_evt),
    .cmp_evt(cmp_evt), .irq(irq)
  );

  function automatic logic [31:0] ctrl_word(input logic [1:0] lo, input logic [1:0] hi);
    return (32'(lo) << 6) | (32'(hi) << 22);
  endfunction

  function automatic logic [31:0] wrap_next(input logic [31:0] c, input int gap, input logic [31:0] p);
    return 32'((64'(c) + 64'(gap)) % (64'(p) + 64'd1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    cap = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c1, c2, p;
    int k1, k2, base;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    foreach (A_LIST[i]) begin
      rd(A_LIST[i], d);
      chk("R1 reg reset", d, 32'h0);
    end
    chk("R1 outputs", {28'h0, lo_evt, hi_evt, cmp_evt, irq}, 32'h0);

    // R2 halves held in reset
    wr(A_PL, 32'hFFFF_FFFF);
    wr(A_PH, 32'd9);
    wr(A_CTRL, ctrl_word(2'b10, 2'b10));
    wr(A_GCTL, 32'h4);
    wr(A_CL, 32'd55);
    idle(10);
    rd(A_CL, d); chk("R2 low held", d, 32'h0);
    rd(A_CH, d); chk("R2 high held", d, 32'h0);

    // R3 released but timer mode not dual: frozen
    wr(A_GCTL, 32'h3);
    idle(5);
    rd(A_CL, d); chk("R3 frozen by timer mode", d, 32'h0);

    // R6 / R11 count write visible next edge
    wr(A_GCTL, 32'h7);
    wr(A_CL, 32'd100);
    rd(A_CL, c1); k1 = cap;
    chk("R6 count load", c1, 32'd100);
    idle(7);
    rd(A_CL, c2); k2 = cap;
    chk("R11 read timing", c2, c1 + 32'(k2 - k1));

    // R4 high half period 9: 10 pulses per 100 cycles
    idle(3);
    base = n_hi;
    idle(100);
    chk("R4 event rate", 32'(n_hi - base), 32'd10);

    // R5 single-shot low, R7 high unaffected
    rd(A_CH, c1); k1 = cap;
    wr(A_CTRL, ctrl_word(2'b00, 2'b10));
    wr(A_CL, 32'd0);
    wr(A_PL, 32'd20);
    base = n_lo;
    wr(A_CTRL, ctrl_word(2'b01, 2'b10));
    idle(40);
    rd(A_CL, d); chk("R5 stops at period", d, 32'd20);
    rd(A_CTRL, d); chk("R5 field cleared", d, ctrl_word(2'b00, 2'b10));
    chk("R5 one pulse", 32'(n_lo - base), 32'd1);
    rd(A_CH, c2); k2 = cap;
    chk("R7 high kept running", c2, wrap_next(c1, k2 - k1, 32'd9));
    rd(A_STAT, d); chk("R9 low flag set", d & 32'h1, 32'h1);
    chk("R9 irq high", {31'h0, irq}, 32'h1);

    // R9 write-one-to-clear
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R9 low flag cleared", d & 32'h1, 32'h0);
    wr(A_CTRL, ctrl_word(2'b00, 2'b00));
    idle(2);
    wr(A_STAT, 32'h7);
    rd(A_STAT, d); chk("R9 all cleared", d, 32'h0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);

    // R3 disabled high half holds
    rd(A_CH, c1);
    idle(6);
    rd(A_CH, c2);
    chk("R3 mode 00 holds", c2, c1);

    // R8 compare event on free-running low half
    wr(A_PL, 32'hFFFF_FFFF);
    wr(A_CTRL, ctrl_word(2'b10, 2'b00));
    rd(A_CL, c1); k1 = cap;
    base = n_cmp;
    wr(A_CMP, c1 + 32'd40);
    idle(80);
    chk("R8 one compare pulse", 32'(n_cmp - base), 32'd1);
    rd(A_STAT, d); chk("R8 compare flag", d & 32'h4, 32'h4);
    rd(A_CL, c2); k2 = cap;
    chk("R8 count undisturbed", c2, c1 + 32'(k2 - k1));
    rd(A_CMP, d); chk("R8 compare readback", d, c1 + 32'd40);

    // R10 unmapped offsets
    wr(8'h3C, 32'hDEAD_BEEF);
    wr(8'h00, 32'h1234_5678);
    rd(8'h3C, d); chk("R10 unmapped read", d, 32'h0);
    rd(8'h00, d); chk("R10 unmapped read", d, 32'h0);
    rd(8'h28, d); chk("R10 unmapped read", d, 32'h0);
    rd(A_PL, d);  chk("R10 period intact", d, 32'hFFFF_FFFF);

    // R4 random periods on the high half
    for (int it = 0; it < 20; it++) begin
      p = 32'($urandom_range(1, 60));
      wr(A_CTRL, ctrl_word(2'b10, 2'b00));
      wr(A_PH, p);
      wr(A_CH, 32'd0);
      wr(A_CTRL, ctrl_word(2'b10, 2'b10));
      idle($urandom_range(0, 40));
      rd(A_CH, c1); k1 = cap;
      chk("R4 count within period", {31'h0, c1 <= p}, 32'h1);
      idle($urandom_range(0, 150));
      rd(A_CH, c2); k2 = cap;
      chk("R4 wrap arithmetic", c2, wrap_next(c1, k2 - k1, p));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [7:0] A_LIST [8] = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h30, 8'h44};
endmodule